// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache placed between a processor port and a block-wide memory port. It holds 1024 lines of four 32-bit words each. Every line carries a tag, a valid flag and a dirty flag. A processor write that hits updates only the cache and marks the line dirty. Memory is written only when that dirty line is later replaced. A write that misses first brings the line in from memory, so writes allocate.

A four-state controller runs every request. It waits for a request, then checks the tag. On a miss it writes back the old line if that line is dirty, and then fetches the new line. After the fetch it returns to the tag check, where the request now hits and completes. The processor holds its request until the ready pulse. Only one request is in progress at a time.

Address layout (32 bits): bits [31:14] are the tag, bits [13:4] select the line, bits [3:2] select the word in the block, and bits [1:0] select a byte and are ignored. Word k of a block occupies bits [32k+31:32k] of the 128-bit memory data. On both ports a read/write bit of 1 means write.

Top module: `wb_dm_cache`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid. The cache does not assert cpu_ready and does not drive mem_valid. The first access to any address misses and causes no write-back.
- R2: A read that hits returns the word selected by address bits [3:2] on cpu_rdata. cpu_ready is high for exactly one cycle, in the cycle after the request is accepted.
- R3: A write that hits replaces only the addressed word of the line and marks the line dirty. The other three words keep their values.
- R4: A miss on a clean or invalid line issues a memory read (mem_write=0) of the block at address {request tag, index, 4'b0000}. The cache holds mem_valid, mem_write and mem_addr steady until mem_ready, and writes nothing back.
- R5: A miss on a dirty line first issues a memory write (mem_write=1) at address {stored tag, index, 4'b0000}, carrying the whole old block on mem_wdata. The write is held until mem_ready. The read of the new block follows directly after it.
- R6: A fetched line is valid and clean, and the request completes only after the controller returns to the tag check. A fetched line that is never written is later replaced without a write-back.
- R7: The request is sampled only when the controller is idle. Changes on cpu_write, cpu_addr or cpu_wdata while a request is in progress have no effect on that request.
- R8: Address bits [1:0] have no effect on hit detection, on the word selected or on the memory address.
- R9: mem_valid is low while the controller is idle or checking the tag. It is never high in the cycle in which cpu_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request strobe, held until cpu_ready |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Read word, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request strobe |
| mem_write | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Block being written back |
| mem_rdata | input | 128 | Fetched block, sampled with mem_ready |
| mem_ready | input | 1 | Memory completion for the current request |

## Verification
The bench runs a behavioural model alongside the design and compares the outputs every cycle. It drives four kinds of traffic:
- Cold reads show that a fetch is the only memory traffic on a clean miss.
- Write hits followed by reads of neighbouring words show that only the addressed word changes.
- Conflicting tags on one index, reached once with a dirty line and once with a clean one, separate the write-back path from the direct fetch path.
- Seeded mixed traffic runs over a few indexes, including the first and last line, with memory latencies of zero to three cycles.

Between phases the bench also changes the request inputs while a request is in progress, flips the byte-offset bits, and applies a reset in the middle of a run with dirty lines present.

// File: rtl/wb_dm_cache_pkg.sv
// Package: shared controller state encoding for the write-back cache.
// Assumes: the controller is the only user of these states.
package wb_dm_cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_EVICT = 2'd2,
        ST_FETCH = 2'd3
    } cache_state_t;
endpackage

// File: rtl/wb_dm_cache_tags.sv
// Module: tag, valid and dirty storage for a direct-mapped cache.
// Reads are combinational at line_idx. A fill writes the tag and marks the
// line valid and clean. mark_dirty sets the dirty flag of the same line.
// Assumes: fill_we and mark_dirty are never high together.
module wb_dm_cache_tags #(
    parameter int TAG_W = 18,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] line_idx,
    input  logic             fill_we,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    // Tag array write; holds no reset state because valid_q guards it.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_mem[line_idx] <= fill_tag;
        end
    end

    // Valid and dirty flags: cleared by reset, set by fill and write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we) begin
            valid_q[line_idx] <= 1'b1;
            dirty_q[line_idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[line_idx] <= 1'b1;
        end
    end

    // Combinational lookup of the indexed line.
    always_comb begin
        rd_tag   = tag_mem[line_idx];
        rd_valid = valid_q[line_idx];
        rd_dirty = dirty_q[line_idx];
    end

    // R6: a line that has just been filled reads back valid and clean.
    assert_fill_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (valid_q[$past(line_idx)] && !dirty_q[$past(line_idx)]));

    // R3: a write hit leaves the line dirty.
    assert_hit_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty |=> dirty_q[$past(line_idx)]);
endmodule

// File: rtl/wb_dm_cache_data.sv
// Module: block data array. It supports a combinational read of a whole
// block, a full-block fill and a single-word update.
// Assumes: fill_we and word_we are never high together.
module wb_dm_cache_data #(
    parameter int IDX_W  = 10,
    parameter int WOFF_W = 2,
    parameter int WORD_W = 32
) (
    input  logic                                clk,
    input  logic [IDX_W-1:0]                    line_idx,
    input  logic                                fill_we,
    input  logic [(WORD_W<<WOFF_W)-1:0]         fill_blk,
    input  logic                                word_we,
    input  logic [WOFF_W-1:0]                   word_sel,
    input  logic [WORD_W-1:0]                   word_data,
    output logic [(WORD_W<<WOFF_W)-1:0]         rd_blk
);
    localparam int LINES = 1 << IDX_W;
    localparam int BLK_W = WORD_W << WOFF_W;

    logic [BLK_W-1:0] blk_mem [LINES];

    // Block writes: a whole block on fill, one word on a write hit.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            blk_mem[line_idx] <= fill_blk;
        end else if (word_we) begin
            blk_mem[line_idx][word_sel*WORD_W +: WORD_W] <= word_data;
        end
    end

    // Combinational read of the indexed block.
    assign rd_blk = blk_mem[line_idx];
endmodule

// File: rtl/wb_dm_cache_ctrl.sv
// Module: four-state miss controller (idle, tag check, evict, fetch).
// A hit completes in the tag check state. A miss goes through eviction when
// the victim is dirty, then fetches the new block and returns to the tag check.
// Assumes: hit and victim_dirty describe the latched request.
module wb_dm_cache_ctrl
    import wb_dm_cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_valid,
    input  logic req_write,
    input  logic hit,
    input  logic victim_dirty,
    input  logic mem_ready,
    output logic take_req,
    output logic cpu_ready,
    output logic mem_valid,
    output logic mem_write,
    output logic fill_we,
    output logic word_we
);
    cache_state_t state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state and output decode.
    always_comb begin
        state_d   = state_q;
        take_req  = 1'b0;
        cpu_ready = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        fill_we   = 1'b0;
        word_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid) begin
                    take_req = 1'b1;
                    state_d  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (hit) begin
                    cpu_ready = 1'b1;
                    word_we   = req_write;
                    state_d   = ST_IDLE;
                end else if (victim_dirty) begin
                    state_d = ST_EVICT;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                if (mem_ready) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    fill_we = 1'b1;
                    state_d = ST_CHECK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R2: the completion pulse lasts one cycle.
    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R4: a pending memory request keeps its direction until accepted.
    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write)));

    // R5: an accepted write-back is followed by the block fetch.
    assert_evict_then_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && mem_ready) |=> (mem_valid && !mem_write));

    // R9: memory is idle while the processor is being answered.
    assert_ready_mem_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_valid);
endmodule

// File: rtl/wb_dm_cache.sv
// Module: top of the direct-mapped write-back, write-allocate data cache.
// It latches the processor request, forms the memory addresses, and connects
// the tag store, the data array and the controller.
// Assumes: the processor holds cpu_valid until cpu_ready, and memory returns
// exactly one mem_ready per request.
module wb_dm_cache #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 10,
    parameter int WOFF_W = 2,
    parameter int BOFF_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_valid,
    input  logic                         cpu_write,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [WORD_W-1:0]            cpu_wdata,
    output logic [WORD_W-1:0]            cpu_rdata,
    output logic                         cpu_ready,
    output logic                         mem_valid,
    output logic                         mem_write,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [(WORD_W<<WOFF_W)-1:0]  mem_wdata,
    input  logic [(WORD_W<<WOFF_W)-1:0]  mem_rdata,
    input  logic                         mem_ready
);
    localparam int OFF_W = WOFF_W + BOFF_W;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int RA_W  = ADDR_W - BOFF_W;
    localparam int BLK_W = WORD_W << WOFF_W;

    logic [RA_W-1:0]   req_addr_q;
    logic [WORD_W-1:0] req_wdata_q;
    logic              req_write_q;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WOFF_W-1:0] req_word;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid, rd_dirty, hit;
    logic              take_req, fill_we, word_we;
    logic [BLK_W-1:0]  rd_blk;
    logic              unused_byte_bits;

    // The byte offset does not take part in any decision.
    assign unused_byte_bits = ^cpu_addr[BOFF_W-1:0];

    // Request latch: captured only when the controller accepts a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            req_write_q <= 1'b0;
        end else if (take_req) begin
            req_addr_q  <= cpu_addr[ADDR_W-1:BOFF_W];
            req_wdata_q <= cpu_wdata;
            req_write_q <= cpu_write;
        end
    end

    // Address fields of the latched request.
    assign req_tag  = req_addr_q[RA_W-1 -: TAG_W];
    assign req_idx  = req_addr_q[WOFF_W +: IDX_W];
    assign req_word = req_addr_q[WOFF_W-1:0];
    assign hit      = rd_valid && (rd_tag == req_tag);

    wb_dm_cache_tags #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_idx   (req_idx),
        .fill_we    (fill_we),
        .fill_tag   (req_tag),
        .mark_dirty (word_we),
        .rd_tag     (rd_tag),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty)
    );

    wb_dm_cache_data #(.IDX_W(IDX_W), .WOFF_W(WOFF_W), .WORD_W(WORD_W)) u_data (
        .clk       (clk),
        .line_idx  (req_idx),
        .fill_we   (fill_we),
        .fill_blk  (mem_rdata),
        .word_we   (word_we),
        .word_sel  (req_word),
        .word_data (req_wdata_q),
        .rd_blk    (rd_blk)
    );

    wb_dm_cache_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_valid    (cpu_valid),
        .req_write    (req_write_q),
        .hit          (hit),
        .victim_dirty (rd_valid && rd_dirty),
        .mem_ready    (mem_ready),
        .take_req     (take_req),
        .cpu_ready    (cpu_ready),
        .mem_valid    (mem_valid),
        .mem_write    (mem_write),
        .fill_we      (fill_we),
        .word_we      (word_we)
    );

    // Processor and memory data paths.
    assign cpu_rdata = rd_blk[req_word*WORD_W +: WORD_W];
    assign mem_wdata = rd_blk;
    assign mem_addr  = mem_write ? {rd_tag,  req_idx, {OFF_W{1'b0}}}
                                 : {req_tag, req_idx, {OFF_W{1'b0}}};

    // R4: the memory address stays put while a request waits.
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> $stable(mem_addr));

    // R6: a fill is followed by the tag check, which then hits.
    assert_fill_then_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (hit && !mem_valid));
endmodule

// File: tb/test_wb_dm_cache.sv
`timescale 1ns/1ps
module test_wb_dm_cache;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cpu_valid, cpu_write;
    logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
    logic         cpu_ready, mem_valid, mem_write;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata;
    logic         mem_ready;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    wb_dm_cache i_wb_dm_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // Behavioural reference: line arrays, a backing store and a phase number.
    bit [17:0]  m_tag [1024];
    bit         m_val [1024];
    bit         m_dty [1024];
    bit [127:0] m_dat [1024];
    bit [127:0] backing [int unsigned];
    int         phase;      // 0 idle, 1 tag check, 2 write-back, 3 fetch
    bit [31:0]  r_addr, r_wdata;
    bit         r_wr;
    int         lat, cnt;

    function automatic bit [127:0] blk_of(input int unsigned key);
        bit [127:0] b;
        if (backing.exists(key)) return backing[key];
        for (int w = 0; w < 4; w++) b[w*32 +: 32] = 32'h5A00_0000 ^ (key << 3) ^ w;
        return b;
    endfunction

    function automatic bit [31:0] mk(input bit [17:0] t, input bit [9:0] i,
                                     input bit [1:0] w, input bit [1:0] b);
        return {t, i, w, b};
    endfunction

    function automatic bit m_hit();
        return m_val[r_addr[13:4]] && (m_tag[r_addr[13:4]] == r_addr[31:14]);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // Reference update at each clock edge, from inputs driven at negedges.
    always @(posedge clk) begin
        int ix;
        ix = r_addr[13:4];
        if (!rst_n) begin
            phase = 0;
            for (int i = 0; i < 1024; i++) begin m_val[i] = 0; m_dty[i] = 0; end
        end else begin
            case (phase)
                0: if (cpu_valid) begin
                       r_addr = cpu_addr; r_wdata = cpu_wdata; r_wr = cpu_write; phase = 1;
                   end
                1: if (m_hit()) begin
                       if (r_wr) begin
                           m_dat[ix][r_addr[3:2]*32 +: 32] = r_wdata;
                           m_dty[ix] = 1;
                       end
                       phase = 0;
                   end else phase = m_dty[ix] ? 2 : 3;
                2: if (mem_ready) begin
                       backing[{m_tag[ix], r_addr[13:4]}] = m_dat[ix];
                       phase = 3;
                   end
                default: if (mem_ready) begin
                       m_dat[ix] = blk_of(r_addr[31:4]);
                       m_tag[ix] = r_addr[31:14];
                       m_val[ix] = 1; m_dty[ix] = 0;
                       phase = 1;
                   end
            endcase
        end
    end

    // Per-cycle comparison and memory responder, away from the active edge.
    always @(negedge clk) begin
        bit         e_rdy;
        bit [31:0]  e_addr;
        int         ix;
        ix = r_addr[13:4];
        if (rst_n) begin
            e_rdy = (phase == 1) && m_hit();
            chk(cpu_ready === e_rdy, "R2", cpu_ready, e_rdy);
            chk(mem_valid === (phase >= 2), "R9", mem_valid, phase >= 2);
            if (e_rdy && !r_wr)
                chk(cpu_rdata === m_dat[ix][r_addr[3:2]*32 +: 32], "R2",
                    cpu_rdata, m_dat[ix][r_addr[3:2]*32 +: 32]);
            if (phase == 2) begin
                e_addr = {m_tag[ix], r_addr[13:4], 4'b0};
                chk(mem_write === 1'b1, "R5", mem_write, 1);
                chk(mem_addr === e_addr, "R5", mem_addr, e_addr);
                chk(mem_wdata === m_dat[ix], "R5", mem_wdata, m_dat[ix]);
            end
            if (phase == 3) begin
                e_addr = {r_addr[31:4], 4'b0};
                chk(mem_write === 1'b0, "R4", mem_write, 0);  // no write-back on clean miss, R6
                chk(mem_addr === e_addr, "R4", mem_addr, e_addr);
            end
            if (phase >= 2 && cnt >= lat) begin
                mem_ready = 1'b1;
                mem_rdata = (phase == 3) ? blk_of(r_addr[31:4]) : '0;
                cnt = 0;
            end else begin
                mem_ready = 1'b0;
                cnt = (phase >= 2) ? cnt + 1 : 0;
            end
        end else begin
            mem_ready = 1'b0;
            cnt = 0;
        end
    end

    // One processor request. scr perturbs the inputs while it is in progress (R7).
    task automatic req(input bit wr, input bit [31:0] a, input bit [31:0] d, input bit scr);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        if (scr) begin cpu_addr = ~a; cpu_wdata = ~d; cpu_write = ~wr; end
        while (cpu_ready !== 1'b1) @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: after reset the cache is quiet on both ports.
        chk(cpu_ready === 1'b0, "R1", cpu_ready, 0);
        chk(mem_valid === 1'b0, "R1", mem_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_write = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; mem_ready = 1'b0; mem_rdata = '0;
        phase = 0; lat = 2; cnt = 0; r_addr = '0; r_wdata = '0; r_wr = 1'b0;
        do_reset();
        // R1, R4: cold read misses and fetches without a write-back.
        req(0, mk(18'h00012, 10'd5, 2'd1, 2'd0), 0, 0);
        // R2, R8: hit on another word with nonzero byte bits.
        req(0, mk(18'h00012, 10'd5, 2'd3, 2'd2), 0, 0);
        // R3, R7: write hit while the inputs are perturbed.
        req(1, mk(18'h00012, 10'd5, 2'd2, 2'd1), 32'hDEADBEEF, 1);
        req(0, mk(18'h00012, 10'd5, 2'd2, 2'd0), 0, 0);   // R3 written word
        req(0, mk(18'h00012, 10'd5, 2'd1, 2'd3), 0, 0);   // R3 neighbour kept
        // R5: conflicting tag on a dirty line, zero-latency memory.
        lat = 0;
        req(0, mk(18'h3FFFF, 10'd5, 2'd0, 2'd0), 0, 0);
        // R6: clean victim replaced directly; data returns from memory.
        lat = 3;
        req(0, mk(18'h00012, 10'd5, 2'd2, 2'd0), 0, 0);
        // Write misses at the first and last line (R4, R5, R6).
        lat = 1;
        req(1, mk(18'h00007, 10'd0, 2'd0, 2'd0), 32'h0000_1234, 0);
        req(1, mk(18'h2AAAA, 10'd1023, 2'd3, 2'd0), 32'hCAFE_0001, 1);
        req(0, mk(18'h15555, 10'd1023, 2'd3, 2'd0), 0, 0);
        req(0, mk(18'h2AAAA, 10'd1023, 2'd3, 2'd2), 0, 0);
        // Mixed traffic over a few lines and tags, varying latency.
        begin
            bit [31:0] s;
            s = 32'h1357_9BDF;
            for (int n = 0; n < 300; n++) begin
                s = s * 32'd1664525 + 32'd1013904223;
                lat = n % 4;
                req(s[0], mk({16'h0, s[3:2]}, {8'h0, s[5:4]} * 10'd341,
                             s[7:6], s[9:8]), s, s[10]);
            end
        end
        // R1: reset in mid-run drops dirty lines; the next access is a clean miss.
        do_reset();
        req(0, mk(18'h00012, 10'd5, 2'd2, 2'd0), 0, 0);
        req(1, mk(18'h00001, 10'd341, 2'd1, 2'd0), 32'h0BAD_F00D, 0);
        req(0, mk(18'h00001, 10'd341, 2'd1, 2'd0), 0, 0);
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule